// File: doc/BRIEF.md
# Dual-Converter Sampling Port Bridge

This block sits between a 32-bit processor bus and a pair of simultaneous-sampling 12-bit analog-to-digital converters that share one set of control lines. The processor reaches the converters through three decoded port addresses, qualified by a single-cycle access strobe and a read/write flag. A write to the start port launches a timed active-low conversion-start pulse on both converters at once. A write to the select port latches which of the two channel pairs they sample. A read of the data port drives chip-select and read-enable low together for that access.

A read returns one 32-bit word that carries a sample from each converter. The first converter's 12 bits sit at the bottom of the lower half-word and the second converter's 12 bits sit at the bottom of the upper half-word. The pad bits are zero. Two successive data-port reads return the two channels of a pair that were converted together. The start pulse is timed from the system clock by a counter, so it always meets the converter's minimum low time. A start request that arrives while a pulse is still running is dropped.

Top module: `adc_pair_bridge`

## Requirements
- R1: After reset, conv_start_n, adc_cs_n and adc_rd_n are 1 and chan_pair is 0.
- R2: A strobed write (bus_rw=0) to address START_PORT (default 0) while no pulse is running drives conv_start_n low from the next clock for exactly PULSE_CYC cycles (default 26, 260 ns at 100 MHz), after which it returns high.
- R3: A start write that arrives while conv_start_n is low neither lengthens nor restarts the running pulse.
- R4: A strobed write to address SEL_PORT (default 2) loads bus_wdata bit 0 into chan_pair from the next clock. chan_pair holds its value through all other cycles.
- R5: In a cycle with a strobed read (bus_rw=1) of address DATA_PORT (default 1), adc_cs_n and adc_rd_n are both 0 in that same cycle. In every other cycle both are 1.
- R6: During a data-port read, bus_rdata[11:0] equals adc0_data, bus_rdata[27:16] equals adc1_data, and bits 15:12 and 31:28 are 0. Outside a data-port read, bus_rdata is all zeros.
- R7: Reads of the start or select port, writes to the data port, and accesses to any other address leave conv_start_n, chan_pair, adc_cs_n, adc_rd_n and bus_rdata unchanged from their idle behaviour.
- R8: With bus_strobe low, no address or read/write value has any effect on the outputs.
- R9: A start write issued in the first cycle after a pulse ends is accepted, so conv_start_n is high for exactly one cycle between back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_strobe | input | 1 | Single-cycle access qualifier from the processor |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W (4) | Port address |
| bus_wdata | input | 32 | Write data; bit 0 carries the channel-pair choice |
| bus_rdata | output | 32 | Packed pair of samples during a data-port read, else zero |
| adc0_data | input | 12 | Parallel output of the first converter |
| adc1_data | input | 12 | Parallel output of the second converter |
| conv_start_n | output | 1 | Shared active-low conversion start |
| adc_cs_n | output | 1 | Shared active-low chip select |
| adc_rd_n | output | 1 | Shared active-low read enable |
| chan_pair | output | 1 | Shared channel-pair select |

## Verification
Chip-select, read-enable and the packed read word are combinational and are due in the same cycle as the read strobe. The bench therefore checks them one time unit after it drives each access, before the next edge. The start pulse and the channel-pair latch change one clock after the accepted write. The bench checks them at the falling edge after each rising edge, against a behavioural model that updates on the same rising edge. Long runs of start writes, including writes on every cycle, exercise the busy window and the one-cycle gap between pulses.

// File: rtl/adc_bridge_pkg.sv
package adc_bridge_pkg;
  typedef struct packed {
    logic start;
    logic fetch;
    logic select;
  } port_hit_t;
endpackage

// File: rtl/abr_decode.sv
module abr_decode
  import adc_bridge_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int START_PORT = 0,
  parameter int DATA_PORT  = 1,
  parameter int SEL_PORT   = 2
) (
  input  logic              strobe,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output port_hit_t         hit
);
  always_comb begin
    hit        = '0;
    hit.start  = strobe && !rw && (addr == ADDR_W'(START_PORT));
    hit.fetch  = strobe &&  rw && (addr == ADDR_W'(DATA_PORT));
    hit.select = strobe && !rw && (addr == ADDR_W'(SEL_PORT));
  end
endmodule

// File: rtl/abr_start_pulse.sv
module abr_start_pulse #(
  parameter int PULSE_CYC = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic conv_n
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             conv_n_q, conv_n_d;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start_req && !busy) begin
      cnt_d = CNT_W'(PULSE_CYC);
    end else if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    conv_n_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      conv_n_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      conv_n_q <= conv_n_d;
    end
  end

  assign conv_n = conv_n_q;

  // Independent low-time counter used only by the checks below.
  logic [CNT_W:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (!conv_n_q) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n_q) |-> (low_run == (CNT_W+1)'(PULSE_CYC)));

  p_fall_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n_q) |-> $past(start_req));

  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= (CNT_W+1)'(PULSE_CYC));
endmodule

// File: rtl/abr_chan_latch.sv
module abr_chan_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_bit,
  output logic chan
);
  logic chan_q, chan_d;

  always_comb begin
    chan_d = chan_q;
    if (load) chan_d = sel_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= 1'b0;
    else        chan_q <= chan_d;
  end

  assign chan = chan_q;

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(chan_q));

  p_sel_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (chan_q == $past(sel_bit)));
endmodule

// File: rtl/adc_pair_bridge.sv
module adc_pair_bridge
  import adc_bridge_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BUS_W      = 32,
  parameter int SAMPLE_W   = 12,
  parameter int START_PORT = 0,
  parameter int DATA_PORT  = 1,
  parameter int SEL_PORT   = 2,
  parameter int PULSE_CYC  = 26
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_strobe,
  input  logic                bus_rw,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [SAMPLE_W-1:0] adc0_data,
  input  logic [SAMPLE_W-1:0] adc1_data,
  output logic                conv_start_n,
  output logic                adc_cs_n,
  output logic                adc_rd_n,
  output logic                chan_pair
);
  localparam int LANES  = 2;
  localparam int LANE_W = BUS_W / LANES;
  localparam int PAD_W  = LANE_W - SAMPLE_W;

  // Reset: asserted asynchronously, released after two clocks.
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  port_hit_t hit;

  abr_decode #(
    .ADDR_W(ADDR_W), .START_PORT(START_PORT),
    .DATA_PORT(DATA_PORT), .SEL_PORT(SEL_PORT)
  ) u_dec (
    .strobe(bus_strobe), .rw(bus_rw), .addr(bus_addr), .hit(hit)
  );

  abr_start_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_int_n), .start_req(hit.start), .conv_n(conv_start_n)
  );

  abr_chan_latch u_chan (
    .clk(clk), .rst_n(rst_int_n), .load(hit.select),
    .sel_bit(bus_wdata[0]), .chan(chan_pair)
  );

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[BUS_W-1:1];

  // Shared read strobes come from the single decoded data port.
  assign adc_cs_n = !hit.fetch;
  assign adc_rd_n = !hit.fetch;

  logic [SAMPLE_W-1:0] lane_src [LANES];
  assign lane_src[0] = adc0_data;
  assign lane_src[1] = adc1_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bus_rdata[g*LANE_W +: LANE_W] =
      hit.fetch ? {{PAD_W{1'b0}}, lane_src[g]} : '0;
  end

  p_decode_onehot_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({hit.start, hit.fetch, hit.select}));

  p_strobe_pair_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    adc_cs_n == adc_rd_n);

  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rdata[LANE_W-1:SAMPLE_W] == '0) && (bus_rdata[BUS_W-1:LANE_W+SAMPLE_W] == '0));

  p_idle_rdata_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    adc_cs_n |-> (bus_rdata == '0));

  p_idle_strobe_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_strobe |-> (adc_cs_n && adc_rd_n));
endmodule

// File: tb/sim_adc_pair_bridge.sv
module sim_adc_pair_bridge;
  localparam int P = 26;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_strobe, bus_rw;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [11:0] adc0_data, adc1_data;
  logic        conv_start_n, adc_cs_n, adc_rd_n, chan_pair;

  adc_pair_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc0_data(adc0_data), .adc1_data(adc1_data),
    .conv_start_n(conv_start_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .chan_pair(chan_pair)
  );

  always #5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string tag    = "R1";

  // Behavioural reference: remaining low cycles and latched pair bit.
  int m_left = 0;
  bit m_pair = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0;
      m_pair = 0;
    end else begin
      if (bus_strobe && !bus_rw && bus_addr == 4'd0 && m_left == 0) m_left = P;
      else if (m_left > 0) m_left = m_left - 1;
      if (bus_strobe && !bus_rw && bus_addr == 4'd2) m_pair = bus_wdata[0];
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_seq();
    check("conv_start_n", {31'b0, conv_start_n}, {31'b0, (m_left == 0)});
    check("chan_pair",    {31'b0, chan_pair},    {31'b0, m_pair});
  endtask

  task automatic check_comb();
    bit rd;
    rd = bus_strobe && bus_rw && bus_addr == 4'd1;
    check("adc_cs_n", {31'b0, adc_cs_n}, {31'b0, !rd});
    check("adc_rd_n", {31'b0, adc_rd_n}, {31'b0, !rd});
    check("bus_rdata", bus_rdata,
          rd ? {4'b0, adc1_data, 4'b0, adc0_data} : 32'h0);
  endtask

  task automatic cyc(bit s, bit rw, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    check_seq();
    bus_strobe = s; bus_rw = rw; bus_addr = a; bus_wdata = d;
    adc0_data = 12'($urandom); adc1_data = 12'($urandom);
    #1;
    check_comb();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'd0, 32'h0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bus_strobe = 0; bus_rw = 0; bus_addr = 0; bus_wdata = 0;
    adc0_data = 0; adc1_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    tag = "R1"; idle(5);

    tag = "R2"; cyc(1, 0, 4'd0, 32'h0); idle(P + 4);

    tag = "R3"; cyc(1, 0, 4'd0, 32'h0); idle(4);
    cyc(1, 0, 4'd0, 32'h0); idle(10);
    cyc(1, 0, 4'd0, 32'h0); idle(P - 17);
    cyc(1, 0, 4'd0, 32'h0); idle(P + 4);

    tag = "R9"; for (int i = 0; i < 3 * P; i++) cyc(1, 0, 4'd0, 32'h0);
    idle(P + 2);

    tag = "R4"; cyc(1, 0, 4'd2, 32'h1); idle(3);
    cyc(1, 0, 4'd2, 32'hFFFF_FFFE); idle(2);
    cyc(1, 0, 4'd2, 32'h3); cyc(1, 0, 4'd2, 32'h3); idle(2);

    tag = "R5"; for (int i = 0; i < 6; i++) cyc(1, 1, 4'd1, 32'h0);
    tag = "R6"; for (int i = 0; i < 6; i++) begin cyc(1, 1, 4'd1, 32'h0); idle(1); end

    tag = "R7";
    cyc(1, 1, 4'd0, 32'h0); cyc(1, 1, 4'd2, 32'h0); cyc(1, 0, 4'd1, 32'h0);
    for (int a = 3; a < 16; a++) begin
      cyc(1, 0, 4'(a), 32'h0); cyc(1, 1, 4'(a), 32'hFFFF_FFFF);
    end
    idle(2);

    tag = "R8";
    for (int a = 0; a < 4; a++) begin
      cyc(0, 0, 4'(a), 32'h0); cyc(0, 1, 4'(a), 32'h0);
      cyc(0, 0, 4'(a), 32'hFFFF_FFFE);
    end
    idle(P + 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule